// File: doc/BRIEF.md
# Modulo Address Generator for Signal-Processing Data Memory

This block computes data-memory addresses for a signal-processing datapath. It holds eight address pointers, each with a companion step (offset) register and a modifier register. A request names one pointer and one of several addressing modes. The block returns the effective address for the access and the pointer value left behind after the access. The pointer register is written back in the same clock edge.

The modifier register of the selected pointer picks the arithmetic used for every step:
- **Linear:** the modifier is all ones, and the pointer steps as a plain 16-bit value.
- **Circular:** the modifier is any other non-zero value, and the pointer wraps inside a buffer of modifier+1 words. This suits filter delay lines.
- **Reverse-carry:** the modifier is zero, and carries travel from the top bit downward. This gives the bit-reversed walk an FFT needs.

Software or a decoder loads the three register sets through one load port. The attached memory and the instruction decoder sit outside this block.

Top module: `dsp_modaddr_gen`

## Requirements
- R1: After reset, every pointer and step register reads 0 and every modifier reads 0xFFFF (linear), and `out_vld` is 0.
- R2: A load with `ld_en`=1 writes `ld_data` into entry `ld_idx` of the set chosen by `ld_sel` (0 = pointer, 1 = step, 2 = modifier, 3 = nothing). A request issued after the load sees the new value.
- R3: A request (`req_en`=1) in one cycle gives `out_vld`=1 in the next cycle, with `out_ea` and `out_ptr` belonging to that request. A cycle with no request gives `out_vld`=0 in the next cycle.
- R4: Mode 0 (plain) gives address r. Mode 1 (indexed) gives address r+n, computed with the modifier arithmetic. In both modes the pointer is left unchanged.
- R5: Mode 2 (post-increment) and mode 3 (post-decrement) give address r. The pointer then becomes r+1 or r-1 under the modifier arithmetic.
- R6: Mode 4 (pre-decrement) first forms r-1 under the modifier arithmetic. That value is both the address and the new pointer.
- R7: Mode 5 (post-add step) and mode 6 (post-subtract step) give address r. The pointer then becomes r+n or r-n under the modifier arithmetic.
- R8: Mode 7 behaves exactly as mode 0.
- R9: A modifier of 0xFFFF gives plain 16-bit arithmetic that wraps at 2^16.
- R10: A modifier m with 0 < m < 0xFFFF gives a circular buffer of M=m+1 words. Let k be the bit width of m. The buffer base is r with its low k bits cleared. A step that leaves the range base..base+m has M subtracted or added once. This holds for steps up to M.
- R11: A modifier of 0 gives reverse-carry arithmetic: the result is bitrev(bitrev(r) ± bitrev(step)) over 16 bits.
- R12: When a pointer load and a request that updates the same pointer occur in the same cycle, the loaded value is stored. The request still reports its own address and computed pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 2 | Load target set: 0 pointer, 1 step, 2 modifier, 3 none |
| ld_idx | input | 3 | Register index for the load |
| ld_data | input | 16 | Load value |
| req_en | input | 1 | Address request strobe |
| req_idx | input | 3 | Pointer selected by the request |
| req_mode | input | 3 | Addressing mode, codes 0 to 7 |
| out_vld | output | 1 | Result valid, one cycle after the request |
| out_ea | output | 16 | Effective address |
| out_ptr | output | 16 | Pointer value after the request |

## Verification
The state is the 24 registers. A wrong value in any of them shows at the ports only when a request uses that register. A corrupted pointer shows in the very next result, on `out_ea` or `out_ptr`. A corrupted step or modifier shows only as a wrong stride or a wrong wrap point, and only after a request that moves the pointer. A wrap error in circular mode therefore appears only when the walk crosses a buffer edge. For this reason the bench walks pointers across both ends of the buffers, and it follows reverse-carry sequences over several steps.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [2:0] {
    AM_PLAIN   = 3'd0,
    AM_INDEX   = 3'd1,
    AM_POSTINC = 3'd2,
    AM_POSTDEC = 3'd3,
    AM_PREDEC  = 3'd4,
    AM_POSTADD = 3'd5,
    AM_POSTSUB = 3'd6,
    AM_RSVD    = 3'd7
  } agu_mode_e;

  typedef enum logic [1:0] {
    LD_PTR  = 2'd0,
    LD_OFS  = 2'd1,
    LD_MOD  = 2'd2,
    LD_NONE = 2'd3
  } agu_ld_e;

endpackage

// File: rtl/agu_regbank.sv
module agu_regbank #(
  parameter int              NREG    = 8,
  parameter int              AW      = 16,
  parameter logic [AW-1:0]   RST_VAL = '0,
  parameter int              IW      = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [AW-1:0] upd_data,
  input  logic [IW-1:0] rd_idx,
  output logic [AW-1:0] rd_data
);

  logic [NREG-1:0][AW-1:0] q;
  logic [NREG-1:0][AW-1:0] q_nxt;
  logic [NREG-1:0]         q_ce;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_comb begin
      q_ce[g]  = 1'b0;
      q_nxt[g] = q[g];
      if (upd_en && (upd_idx == IW'(g))) begin
        q_ce[g]  = 1'b1;
        q_nxt[g] = upd_data;
      end
      if (wr_en && (wr_idx == IW'(g))) begin
        q_ce[g]  = 1'b1;
        q_nxt[g] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q[g] <= RST_VAL;
      else if (q_ce[g]) q[g] <= q_nxt[g];
    end
  end

  assign rd_data = q[rd_idx];

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q[$past(wr_idx)] == $past(wr_data)); // R12

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_en) |=> $stable(q)); // R4

endmodule

// File: rtl/agu_arith.sv
module agu_arith #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_ptr,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] modv,
  input  logic          sub,
  output logic [AW-1:0] result
);

  function automatic logic [AW-1:0] brev(input logic [AW-1:0] v);
    logic [AW-1:0] o;
    for (int i = 0; i < AW; i++) o[i] = v[AW-1-i];
    return o;
  endfunction

  logic          is_lin;
  logic          is_rev;
  logic [AW-1:0] mask;
  logic [AW-1:0] lin_res;
  logic [AW-1:0] rev_sum;
  logic [AW-1:0] rev_res;
  logic [AW:0]   off_w;
  logic [AW:0]   size_w;
  logic [AW:0]   t_w;
  logic [AW-1:0] mod_res;

  assign is_lin = &modv;
  assign is_rev = (modv == '0);

  // smear the top set bit of the modifier downward to get the block mask
  always_comb begin
    mask = modv;
    for (int s = 1; s < AW; s = s * 2) mask = mask | (mask >> s);
  end

  assign lin_res = sub ? (base_ptr - step) : (base_ptr + step);
  assign rev_sum = sub ? (brev(base_ptr) - brev(step))
                       : (brev(base_ptr) + brev(step));
  assign rev_res = brev(rev_sum);

  always_comb begin
    off_w  = {1'b0, base_ptr & mask};
    size_w = {1'b0, modv} + 1'b1;
    if (!sub) begin
      t_w = off_w + {1'b0, step};
      if (t_w >= size_w) t_w = t_w - size_w;
    end else begin
      t_w = off_w - {1'b0, step};
      if (t_w[AW]) t_w = t_w + size_w;
    end
    mod_res = (base_ptr & ~mask) | (t_w[AW-1:0] & mask);
  end

  always_comb begin
    if (is_lin)      result = lin_res;
    else if (is_rev) result = rev_res;
    else             result = mod_res;
  end

  always_comb begin
    if (!is_lin && !is_rev && ((base_ptr & mask) <= modv) &&
        ({1'b0, step} <= ({1'b0, modv} + 1'b1))) begin
      AST_MOD_IN_BUFFER: assert (((result & ~mask) == (base_ptr & ~mask)) &&
                                 ((result & mask) <= modv)); // R10
    end
  end

endmodule

// File: rtl/dsp_modaddr_gen.sv
module dsp_modaddr_gen #(
  parameter int NREG = 8,
  parameter int AW   = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_idx,
  input  logic [AW-1:0] ld_data,
  input  logic          req_en,
  input  logic [IW-1:0] req_idx,
  input  logic [2:0]    req_mode,
  output logic          out_vld,
  output logic [AW-1:0] out_ea,
  output logic [AW-1:0] out_ptr
);
  import agu_pkg::*;

  localparam logic [AW-1:0] ONE = AW'(1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  agu_ld_e   ld_kind;
  agu_mode_e mode;
  assign ld_kind = agu_ld_e'(ld_sel);
  assign mode    = agu_mode_e'(req_mode);

  logic [AW-1:0] cur_ptr, cur_ofs, cur_mod;
  logic [AW-1:0] step, arith_res, ea_nxt, ptr_nxt;
  logic          sub, ptr_wr;

  agu_regbank #(.NREG(NREG), .AW(AW), .RST_VAL('0)) i_ptr_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(ld_en && (ld_kind == LD_PTR)), .wr_idx(ld_idx), .wr_data(ld_data),
    .upd_en(req_en && ptr_wr), .upd_idx(req_idx), .upd_data(ptr_nxt),
    .rd_idx(req_idx), .rd_data(cur_ptr)
  );

  agu_regbank #(.NREG(NREG), .AW(AW), .RST_VAL('0)) i_ofs_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(ld_en && (ld_kind == LD_OFS)), .wr_idx(ld_idx), .wr_data(ld_data),
    .upd_en(1'b0), .upd_idx(req_idx), .upd_data(ld_data),
    .rd_idx(req_idx), .rd_data(cur_ofs)
  );

  agu_regbank #(.NREG(NREG), .AW(AW), .RST_VAL('1)) i_mod_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(ld_en && (ld_kind == LD_MOD)), .wr_idx(ld_idx), .wr_data(ld_data),
    .upd_en(1'b0), .upd_idx(req_idx), .upd_data(ld_data),
    .rd_idx(req_idx), .rd_data(cur_mod)
  );

  // mode decode: unit step or register step, direction, write-back
  always_comb begin
    step   = cur_ofs;
    sub    = 1'b0;
    ptr_wr = 1'b0;
    unique case (mode)
      AM_POSTINC: begin step = ONE; ptr_wr = 1'b1; end
      AM_POSTDEC: begin step = ONE; sub = 1'b1; ptr_wr = 1'b1; end
      AM_PREDEC:  begin step = ONE; sub = 1'b1; ptr_wr = 1'b1; end
      AM_POSTADD: ptr_wr = 1'b1;
      AM_POSTSUB: begin sub = 1'b1; ptr_wr = 1'b1; end
      default:    ;
    endcase
  end

  agu_arith #(.AW(AW)) i_arith (
    .base_ptr(cur_ptr), .step(step), .modv(cur_mod), .sub(sub),
    .result(arith_res)
  );

  always_comb begin
    ptr_nxt = ptr_wr ? arith_res : cur_ptr;
    if ((mode == AM_PREDEC) || (mode == AM_INDEX)) ea_nxt = arith_res;
    else                                           ea_nxt = cur_ptr;
  end

  // result register, enabled by the request strobe
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_vld <= 1'b0;
    else            out_vld <= req_en;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_ea  <= '0;
      out_ptr <= '0;
    end else if (req_en) begin
      out_ea  <= ea_nxt;
      out_ptr <= ptr_nxt;
    end
  end

  AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_en |=> out_vld); // R3

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_en |=> !out_vld); // R3

  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_en && (req_mode == 3'd4)) |=> (out_ea == out_ptr)); // R6

  AST_NOMOVE_PTR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_en && ((req_mode == 3'd0) || (req_mode == 3'd7)))
      |=> (out_ptr == out_ea)); // R8

endmodule

// File: tb/test_dsp_modaddr_gen.sv
`timescale 1ns/1ps
module test_dsp_modaddr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [1:0]  ld_sel = 2'd3;
  logic [2:0]  ld_idx = 3'd0;
  logic [15:0] ld_data = 16'd0;
  logic        req_en = 1'b0;
  logic [2:0]  req_idx = 3'd0;
  logic [2:0]  req_mode = 3'd0;
  logic        out_vld;
  logic [15:0] out_ea, out_ptr;

  int total = 0;
  int bad = 0;

  logic [15:0] mp [8];
  logic [15:0] mn [8];
  logic [15:0] mm [8];

  always #2.5 clk = ~clk;

  dsp_modaddr_gen i_dsp_modaddr_gen (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .req_en(req_en), .req_idx(req_idx), .req_mode(req_mode),
    .out_vld(out_vld), .out_ea(out_ea), .out_ptr(out_ptr)
  );

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] o = '0;
    for (int i = 0; i < 16; i++) if (v[i]) o[15-i] = 1'b1;
    return o;
  endfunction

  // reference stepping from the requirement text
  function automatic logic [15:0] ref_step(input logic [15:0] r, input logic [15:0] st,
                                           input bit dn, input logic [15:0] m);
    int k, blk, lo, size, t;
    if (m == 16'hFFFF) return dn ? r - st : r + st;
    if (m == 16'h0000) return rev16(dn ? rev16(r) - rev16(st) : rev16(r) + rev16(st));
    k = 0;
    while ((1 << k) <= int'(m)) k++;
    blk  = 1 << k;
    lo   = int'(r) % blk;
    size = int'(m) + 1;
    t    = dn ? lo - int'(st) : lo + int'(st);
    if (t >= size) t -= size;
    if (t < 0) t += size;
    return 16'(int'(r) - lo + t);
  endfunction

  task automatic expect_of(input int idx, input int md,
                           output logic [15:0] ea, output logic [15:0] np);
    logic [15:0] r = mp[idx];
    logic [15:0] n = mn[idx];
    logic [15:0] m = mm[idx];
    case (md)
      1: begin ea = ref_step(r, n, 0, m); np = r; end
      2: begin ea = r; np = ref_step(r, 16'd1, 0, m); end
      3: begin ea = r; np = ref_step(r, 16'd1, 1, m); end
      4: begin np = ref_step(r, 16'd1, 1, m); ea = np; end
      5: begin ea = r; np = ref_step(r, n, 0, m); end
      6: begin ea = r; np = ref_step(r, n, 1, m); end
      default: begin ea = r; np = r; end
    endcase
  endtask

  task automatic load(input int sel, input int idx, input logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 2'(sel); ld_idx = 3'(idx); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0; ld_sel = 2'd3;
    case (sel)
      0: mp[idx] = d;
      1: mn[idx] = d;
      2: mm[idx] = d;
      default: ;
    endcase
  endtask

  task automatic req(input string tag, input int idx, input int md);
    logic [15:0] ea, np;
    expect_of(idx, md, ea, np);
    @(negedge clk);
    req_en = 1'b1; req_idx = 3'(idx); req_mode = 3'(md);
    @(negedge clk);
    req_en = 1'b0;
    chk({tag, " vld R3"}, {15'd0, out_vld}, 16'd1);
    chk({tag, " ea"}, out_ea, ea);
    chk({tag, " ptr"}, out_ptr, np);
    mp[idx] = np;
  endtask

  task automatic setup(input int idx, input logic [15:0] m, input logic [15:0] n,
                       input logic [15:0] r);
    load(2, idx, m);
    load(1, idx, n);
    load(0, idx, r);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin mp[i] = 16'h0; mn[i] = 16'h0; mm[i] = 16'hFFFF; end
    #12 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 vld after reset", {15'd0, out_vld}, 16'd0);
    req("R1 ptr3 reads zero", 3, 0);
    req("R1 modifier linear, R9 wrap below zero", 0, 3);
    chk("R1/R9 decrement of 0 gives FFFF", mp[0], 16'hFFFF);

    // R3: idle cycle clears valid
    @(negedge clk);
    chk("R3 idle clears vld", {15'd0, out_vld}, 16'd0);

    // R9: linear, wrap at top
    setup(1, 16'hFFFF, 16'h0010, 16'hFFFF);
    req("R9 postinc wraps", 1, 2);
    chk("R9 value", mp[1], 16'h0000);
    req("R4 plain", 1, 0);
    req("R4 indexed", 1, 1);
    req("R8 mode7", 1, 7);
    req("R7 postadd", 1, 5);
    req("R7 postsub", 1, 6);

    // R2: ignored load selector 3 leaves pointer alone
    load(3, 1, 16'h1234);
    req("R2 sel3 ignored", 1, 0);
    chk("R2 sel3 ptr value", out_ptr, 16'h0000);

    // R10: circular buffer of 10 words
    setup(2, 16'd9, 16'd4, 16'h0029);
    req("R10 R5 postinc top wrap", 2, 2);
    chk("R10 top wraps to base", out_ptr, 16'h0020);
    req("R10 R5 postdec bottom wrap", 2, 3);
    chk("R10 bottom wraps to top", out_ptr, 16'h0029);
    load(0, 2, 16'h0028);
    req("R10 R7 postadd wrap", 2, 5);
    chk("R10 step 4 from 8", out_ptr, 16'h0022);
    load(0, 2, 16'h0020);
    req("R10 R6 predec wrap", 2, 4);
    chk("R6 predec ea", out_ea, 16'h0029);
    req("R10 R4 indexed wrap", 2, 1);
    chk("R4 index ea", out_ea, 16'h0023);

    // R11: reverse carry, 16-point FFT order
    setup(3, 16'h0000, 16'd8, 16'h0000);
    req("R11 step1", 3, 5);
    chk("R11 0->8", out_ptr, 16'd8);
    req("R11 step2", 3, 5);
    chk("R11 8->4", out_ptr, 16'd4);
    req("R11 step3", 3, 5);
    chk("R11 4->12", out_ptr, 16'd12);
    req("R11 backward", 3, 6);
    chk("R11 12->4", out_ptr, 16'd4);

    // R12: same-cycle load and update of one pointer
    setup(4, 16'hFFFF, 16'd3, 16'h0100);
    @(negedge clk);
    req_en = 1'b1; req_idx = 3'd4; req_mode = 3'd2;
    ld_en = 1'b1; ld_sel = 2'd0; ld_idx = 3'd4; ld_data = 16'h0555;
    @(negedge clk);
    req_en = 1'b0; ld_en = 1'b0; ld_sel = 2'd3;
    chk("R12 ea of request", out_ea, 16'h0100);
    chk("R12 computed ptr", out_ptr, 16'h0101);
    mp[4] = 16'h0555;
    req("R12 load kept", 4, 0);
    chk("R12 stored value", out_ptr, 16'h0555);

    // random phase
    for (int round = 0; round < 60; round++) begin
      int idx = int'($urandom_range(7, 0));
      int cls = int'($urandom_range(2, 0));
      logic [15:0] m, n, r;
      if (cls == 0) begin
        m = 16'hFFFF; n = 16'($urandom); r = 16'($urandom);
      end else if (cls == 1) begin
        m = 16'h0000; n = 16'(1 << $urandom_range(15, 0)); r = 16'($urandom);
      end else begin
        int k;
        m = 16'($urandom_range(60, 1));
        n = 16'($urandom_range(int'(m) + 1, 0));
        k = 0;
        while ((1 << k) <= int'(m)) k++;
        r = 16'((int'($urandom_range(255, 0)) << k) + int'($urandom_range(int'(m), 0)));
      end
      setup(idx, m, n, r);
      for (int j = 0; j < 6; j++) req("R4-R11 random", idx, int'($urandom_range(7, 0)));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule